// File: doc/BRIEF.md
# Low-Power Mode Controller

This block governs the two reduced-power states of an 8-bit microcontroller core. Software requests a state by writing a two-bit control value. The request takes effect at the next instruction boundary. In the light-sleep state the CPU clock enable drops while the peripheral clock enable stays high, so timers, the serial port and interrupt logic keep running. In the deep-sleep state both enables drop. This stands in for a stopped oscillator. The block also decides how the external bus pins behave in each state, taking into account whether code is fetched from on-chip or off-chip memory.

Light sleep ends on any enabled pending interrupt, and execution then resumes in the service routine. Deep sleep ignores interrupts: only the internal reset ends it. The internal reset comes from a filter on the raw reset pin. The filter asserts only after the pin has stayed high for a parameterised number of consecutive clocks, which defaults to two machine cycles of 12 oscillator clocks each. Clearing of the register bank is left to the core. Memory contents are outside this block.

The filter and mode logic run on the free-running oscillator clock. The enables they produce gate the downstream clock domains. The control register reads back as `mode_idle_o` and `mode_pd_o`.

Top module: `pmc_top`

## Requirements
- R1: A write with `wdata_i[0]`=1 (and `wdata_i[1]`=0) sets `mode_idle_o` on the next cycle, with `cpu_clk_en_o` still 1. After the first clock edge that samples `instr_end_i`=1, `cpu_clk_en_o`=0 and `per_clk_en_o`=1.
- R2: A write with `wdata_i[1]`=1 sets `mode_pd_o`. After the first clock edge that samples `instr_end_i`=1, both `cpu_clk_en_o` and `per_clk_en_o` are 0.
- R3: A write with both bits 1 sets only `mode_pd_o`; `mode_idle_o` stays 0. The two mode bits are never 1 together.
- R4: In light sleep, the edge that samples `irq_pend_i`=1 sets `cpu_clk_en_o` to 1 and clears `mode_idle_o`.
- R5: In deep sleep, `irq_pend_i` has no effect. Both enables stay 0 until the internal reset is asserted, and the edge after that restores them.
- R6: `sys_rst_o` rises after the HOLD_CYCLES-th consecutive clock edge that samples `rst_pin_i`=1. Shorter high pulses never raise it. It falls on the first edge that samples the pin low.
- R7: While `sys_rst_o`=1, the controller returns to running, clears both mode bits on the following edge, and ignores register writes.
- R8: `strobe_ovr_o` is 1 exactly when the CPU clock is stopped. `ale_lvl_o` and `psen_n_lvl_o` are 1 in light sleep and 0 in deep sleep.
- R9: With `ext_code_i`=1, `p0_hiz_o`=1 in both sleep states, and `p2_addr_hold_o`=1 in light sleep only. With `ext_code_i`=0, both are 0. While running, both are always 0.
- R10: A write with both bits 0, or any write made while asleep, changes neither the mode bits nor the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset of this block |
| reg_wr_i | input | 1 | Write strobe for the power-control bits |
| wdata_i | input | 2 | Bit 0 requests light sleep, bit 1 requests deep sleep |
| instr_end_i | input | 1 | Current instruction completes this cycle |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| rst_pin_i | input | 1 | Raw external reset pin (synchronised) |
| ext_code_i | input | 1 | 1 when code is fetched from external memory |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| sys_rst_o | output | 1 | Filtered internal reset |
| mode_idle_o | output | 1 | Light-sleep control bit |
| mode_pd_o | output | 1 | Deep-sleep control bit |
| strobe_ovr_o | output | 1 | Override address-latch and program-strobe pins |
| ale_lvl_o | output | 1 | Forced level for the address-latch pin |
| psen_n_lvl_o | output | 1 | Forced level for the program-strobe pin |
| p0_hiz_o | output | 1 | Float the multiplexed address/data port |
| p2_addr_hold_o | output | 1 | High-address port keeps the address instead of its data latch |

## Verification
On every cycle the assertions check the following: that the mode bits are never both set, that deep sleep persists until the internal reset, that light sleep always ends on an interrupt, that pin overrides match the clock state, and that the internal reset never rises before the required high window, which a counter in the checker measures. Other behaviour shows only in the bench scenarios. This covers the exact cycle on which a request takes effect at the instruction boundary, the pin levels for each combination of memory select and mode, the sweep of reset pulse lengths around the threshold, and the ignoring of writes made during reset or sleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_t;

  localparam int unsigned REQ_IDLE_BIT = 0;
  localparam int unsigned REQ_DOWN_BIT = 1;
  localparam int unsigned REQ_W        = 2;
endpackage

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
  parameter int unsigned HOLD_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rst_o
);
  localparam int unsigned CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // Counts consecutive high samples; saturates one below the threshold so
  // that the next high sample qualifies the reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rst_o <= 1'b0;
    end else if (!pin_i) begin
      cnt_q <= '0;
      rst_o <= 1'b0;
    end else begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      rst_o <= (cnt_q == LAST);
    end
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_rst_i,
  input  logic             wr_i,
  input  logic [REQ_W-1:0] wdata_i,
  input  logic             instr_end_i,
  input  logic             irq_i,
  output pm_state_t        nxt_o,
  output logic             idle_bit_o,
  output logic             down_bit_o
);
  pm_state_t st_q;
  pm_state_t nxt;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      PM_RUN: begin
        if (instr_end_i && down_bit_o)      nxt = PM_DOWN;
        else if (instr_end_i && idle_bit_o) nxt = PM_IDLE;
      end
      PM_IDLE: if (irq_i) nxt = PM_RUN;
      PM_DOWN: nxt = PM_DOWN;
      default: nxt = PM_RUN;
    endcase
    if (sys_rst_i) nxt = PM_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PM_RUN;
    end else begin
      st_q <= nxt;
    end
  end

  // Control bits: writable only while running, deep sleep wins a tie,
  // cleared on any exit.
  always_ff @(posedge clk) begin
    if (rst || sys_rst_i) begin
      idle_bit_o <= 1'b0;
      down_bit_o <= 1'b0;
    end else if (st_q == PM_RUN) begin
      if (wr_i && wdata_i[REQ_DOWN_BIT]) begin
        down_bit_o <= 1'b1;
        idle_bit_o <= 1'b0;
      end else if (wr_i && wdata_i[REQ_IDLE_BIT] && !down_bit_o) begin
        idle_bit_o <= 1'b1;
      end
    end else if (st_q == PM_IDLE && nxt == PM_RUN) begin
      idle_bit_o <= 1'b0;
    end
  end

  assign nxt_o = nxt;
endmodule

// File: rtl/pmc_pin_ctrl.sv
module pmc_pin_ctrl
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_t nxt_i,
  input  logic      ext_code_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      strobe_ovr_o,
  output logic      ale_lvl_o,
  output logic      psen_n_lvl_o,
  output logic      p0_hiz_o,
  output logic      p2_addr_hold_o
);
  logic asleep;
  logic light;

  assign asleep = (nxt_i != PM_RUN);
  assign light  = (nxt_i == PM_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en_o   <= 1'b1;
      per_clk_en_o   <= 1'b1;
      strobe_ovr_o   <= 1'b0;
      ale_lvl_o      <= 1'b0;
      psen_n_lvl_o   <= 1'b0;
      p0_hiz_o       <= 1'b0;
      p2_addr_hold_o <= 1'b0;
    end else begin
      cpu_clk_en_o   <= !asleep;
      per_clk_en_o   <= (nxt_i != PM_DOWN);
      strobe_ovr_o   <= asleep;
      ale_lvl_o      <= light;
      psen_n_lvl_o   <= light;
      p0_hiz_o       <= asleep && ext_code_i;
      p2_addr_hold_o <= light && ext_code_i;
    end
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr_i,
  input  logic [1:0] wdata_i,
  input  logic       instr_end_i,
  input  logic       irq_pend_i,
  input  logic       rst_pin_i,
  input  logic       ext_code_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       sys_rst_o,
  output logic       mode_idle_o,
  output logic       mode_pd_o,
  output logic       strobe_ovr_o,
  output logic       ale_lvl_o,
  output logic       psen_n_lvl_o,
  output logic       p0_hiz_o,
  output logic       p2_addr_hold_o
);
  pm_state_t nxt;

  pmc_rst_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .pin_i (rst_pin_i),
    .rst_o (sys_rst_o)
  );

  pmc_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sys_rst_i   (sys_rst_o),
    .wr_i        (reg_wr_i),
    .wdata_i     (wdata_i),
    .instr_end_i (instr_end_i),
    .irq_i       (irq_pend_i),
    .nxt_o       (nxt),
    .idle_bit_o  (mode_idle_o),
    .down_bit_o  (mode_pd_o)
  );

  pmc_pin_ctrl u_pins (
    .clk            (clk),
    .rst            (rst),
    .nxt_i          (nxt),
    .ext_code_i     (ext_code_i),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .strobe_ovr_o   (strobe_ovr_o),
    .ale_lvl_o      (ale_lvl_o),
    .psen_n_lvl_o   (psen_n_lvl_o),
    .p0_hiz_o       (p0_hiz_o),
    .p2_addr_hold_o (p2_addr_hold_o)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned HOLD_CYCLES = 24
) (
  input logic clk,
  input logic rst,
  input logic irq_pend_i,
  input logic rst_pin_i,
  input logic ext_code_i,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic sys_rst_o,
  input logic mode_idle_o,
  input logic mode_pd_o,
  input logic strobe_ovr_o,
  input logic p0_hiz_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !rst_pin_i) hi_cnt <= '0;
    else if (hi_cnt < HOLD_CYCLES) hi_cnt <= hi_cnt + 1;
  end

  assert_bits_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(mode_idle_o && mode_pd_o));

  assert_down_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!per_clk_en_o && !sys_rst_o) |=> !per_clk_en_o);

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en_o && per_clk_en_o && irq_pend_i) |=> cpu_clk_en_o);

  assert_rst_window_R6: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> (hi_cnt >= HOLD_CYCLES));

  assert_rst_release_R6: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_i |=> !sys_rst_o);

  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (rst)
    strobe_ovr_o == !cpu_clk_en_o);

  assert_p0_needs_ext_R9: assert property (@(posedge clk) disable iff (rst)
    p0_hiz_o |-> ($past(ext_code_i) && !cpu_clk_en_o));
endmodule

bind pmc_top pmc_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_pend_i   (irq_pend_i),
  .rst_pin_i    (rst_pin_i),
  .ext_code_i   (ext_code_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .sys_rst_o    (sys_rst_o),
  .mode_idle_o  (mode_idle_o),
  .mode_pd_o    (mode_pd_o),
  .strobe_ovr_o (strobe_ovr_o),
  .p0_hiz_o     (p0_hiz_o)
);

// File: tb/tb_pmc_top.sv
`timescale 1ns/1ps
module tb_pmc_top;
  localparam int unsigned HOLD = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_i = 1'b0;
  logic [1:0] wdata_i = 2'b00;
  logic instr_end_i = 1'b0;
  logic irq_pend_i = 1'b0;
  logic rst_pin_i = 1'b0;
  logic ext_code_i = 1'b0;
  logic cpu_clk_en_o, per_clk_en_o, sys_rst_o, mode_idle_o, mode_pd_o;
  logic strobe_ovr_o, ale_lvl_o, psen_n_lvl_o, p0_hiz_o, p2_addr_hold_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmc_top #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .wdata_i(wdata_i),
    .instr_end_i(instr_end_i), .irq_pend_i(irq_pend_i), .rst_pin_i(rst_pin_i),
    .ext_code_i(ext_code_i), .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o), .sys_rst_o(sys_rst_o),
    .mode_idle_o(mode_idle_o), .mode_pd_o(mode_pd_o),
    .strobe_ovr_o(strobe_ovr_o), .ale_lvl_o(ale_lvl_o),
    .psen_n_lvl_o(psen_n_lvl_o), .p0_hiz_o(p0_hiz_o),
    .p2_addr_hold_o(p2_addr_hold_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] v);
    reg_wr_i = 1'b1; wdata_i = v;
    step();
    reg_wr_i = 1'b0; wdata_i = 2'b00;
  endtask

  task automatic end_instr();
    instr_end_i = 1'b1;
    step();
    instr_end_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // reset state
    check("R7 reset cpu_en", cpu_clk_en_o, 1);
    check("R7 reset per_en", per_clk_en_o, 1);
    check("R7 reset bits", {mode_pd_o, mode_idle_o}, 0);
    check("R8 reset no override", strobe_ovr_o, 0);
    check("R6 reset sys_rst", sys_rst_o, 0);

    for (int e = 0; e < 2; e++) begin
      ext_code_i = e[0];
      // light sleep
      write(2'b01);
      check("R1 idle bit set", mode_idle_o, 1);
      check("R1 waits boundary", cpu_clk_en_o, 1);
      end_instr();
      check("R1 cpu stopped", cpu_clk_en_o, 0);
      check("R1 per running", per_clk_en_o, 1);
      check("R8 idle strobe ovr", strobe_ovr_o, 1);
      check("R8 idle levels", {ale_lvl_o, psen_n_lvl_o}, 2'b11);
      check("R9 idle p0", p0_hiz_o, e);
      check("R9 idle p2", p2_addr_hold_o, e);
      write(2'b10);
      check("R10 write in idle pd", mode_pd_o, 0);
      check("R10 write in idle per", per_clk_en_o, 1);
      irq_pend_i = 1'b1;
      step();
      irq_pend_i = 1'b0;
      check("R4 wake cpu", cpu_clk_en_o, 1);
      check("R4 idle bit cleared", mode_idle_o, 0);
      check("R9 run p0", p0_hiz_o, 0);
      check("R8 run no override", strobe_ovr_o, 0);

      // deep sleep with both bits written
      write(2'b11);
      check("R3 pd wins", {mode_pd_o, mode_idle_o}, 2'b10);
      check("R2 waits boundary", per_clk_en_o, 1);
      end_instr();
      check("R2 cpu stopped", cpu_clk_en_o, 0);
      check("R2 per stopped", per_clk_en_o, 0);
      check("R8 pd levels", {strobe_ovr_o, ale_lvl_o, psen_n_lvl_o}, 3'b100);
      check("R9 pd p0", p0_hiz_o, e);
      check("R9 pd p2", p2_addr_hold_o, 0);
      irq_pend_i = 1'b1;
      repeat (5) step();
      irq_pend_i = 1'b0;
      check("R5 irq ignored", {cpu_clk_en_o, per_clk_en_o, mode_pd_o}, 3'b001);
      rst_pin_i = 1'b1;
      repeat (HOLD) step();
      check("R6 sys_rst after window", sys_rst_o, 1);
      check("R5 still down at reset", per_clk_en_o, 0);
      write(2'b01);
      check("R5 exit by reset", {cpu_clk_en_o, per_clk_en_o}, 2'b11);
      check("R7 bits cleared, write ignored", {mode_pd_o, mode_idle_o}, 0);
      rst_pin_i = 1'b0;
      step();
      check("R6 release", sys_rst_o, 0);
    end

    // zero-bit write
    write(2'b00);
    end_instr();
    end_instr();
    check("R10 zero write", {cpu_clk_en_o, mode_pd_o, mode_idle_o}, 3'b100);

    // pulse length sweep around the threshold
    for (int len = 1; len <= HOLD + 2; len++) begin
      logic seen;
      seen = 1'b0;
      rst_pin_i = 1'b1;
      for (int k = 1; k <= len; k++) begin
        step();
        if (sys_rst_o) seen = 1'b1;
        if (k == HOLD - 1) check("R6 not before window", sys_rst_o, 0);
      end
      check($sformatf("R6 pulse len %0d", len), seen, (len >= HOLD) ? 1 : 0);
      rst_pin_i = 1'b0;
      step();
      check("R6 low clears", sys_rst_o, 0);
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule